// File: doc/BRIEF.md
# Sector Error Statistics Collector

After a decode pass has left one error count per sector in a small bank of 32-bit words, this block walks that bank and condenses it into three figures. The first is how many sectors could not be repaired. The second is how many bits were repaired in total. The third is the worst repaired count seen in any single sector. Each word holds four sectors, one per 8-bit lane. Of each lane, only a 6-bit or a 7-bit field is meaningful, and the width is chosen per walk. A field whose every bit is set marks a sector that could not be repaired.

A walk begins with a one-cycle `start` together with a sector count. The block then takes one sector per clock through a synchronous-read bank that can map to block RAM, and pulses `done` when the figures are final. The figures stay on the outputs until the next accepted start. The bank is loaded through a plain word-write port.

Top module: `sector_err_stats`

## Requirements
- R1: Sector k is read from bank word k/4, in bits [8*(k%4)+7 : 8*(k%4)] of that word (lane 0 in the low byte).
- R2: `wide_field` is sampled with an accepted start. A value of 0 keeps the low 6 bits of each lane (field mask 0x3F) and a value of 1 keeps the low 7 bits (mask 0x7F). Lane bits above the field have no effect on any result.
- R3: A masked field equal to the mask adds one to `failed_cnt` and touches neither `corrected_sum` nor `max_flips`.
- R4: Every other masked field is added to `corrected_sum`.
- R5: `max_flips` is the largest masked field among sectors that did not fail, and 0 when there is no such field or all are zero.
- R6: In the cycle after an accepted start, all three results read 0.
- R7: With N sectors (N > 0) and a start accepted at clock edge E, `done` is high for the single cycle that follows edge E+N+1, and the results are final in that cycle.
- R8: With N = 0, `done` is high in the cycle that follows the accepting edge, and all results are 0.
- R9: From reset and after `done`, the results hold their values until the next accepted start. Reset clears them to 0 and `done` to 0.
- R10: A start is ignored from the accepting edge up to and including the edge that raises `done`. A start held in the cycle where `done` is high is accepted.
- R11: A sector count above MAX_SECTORS is treated as MAX_SECTORS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_we | input | 1 | Bank word write enable |
| bank_waddr | input | AW | Bank word index |
| bank_wdata | input | 32 | Word of four packed sector counts |
| start | input | 1 | Begin a walk |
| sector_cnt | input | CNT_W | Number of sectors to walk |
| wide_field | input | 1 | 0: 6-bit fields, 1: 7-bit fields |
| done | output | 1 | One-cycle pulse when results are final |
| failed_cnt | output | CNT_W | Sectors that could not be repaired |
| corrected_sum | output | SUM_W | Total repaired bits |
| max_flips | output | 7 | Worst repaired sector count |

## Verification
The finish of one walk and the acceptance of the next can fall into the same cycle. A new start held high in the cycle where `done` is asserted must be taken, while the same start seen one edge earlier, during the last accumulation, must be dropped. The bench provokes this by holding `start` across both of those edges with a different sector count and field width. A reference model, which tracks acceptance only from the requirement timing, predicts the clearing, the per-sector partial results and the second `done` on every clock.

// File: rtl/sector_stats_pkg.sv
package sector_stats_pkg;
  localparam int LANE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = LANE_W * LANES;
  localparam int FIELD_W = 7;
  localparam logic [FIELD_W-1:0] NARROW_MASK = 7'h3F;
  localparam logic [FIELD_W-1:0] WIDE_MASK   = 7'h7F;

  function automatic logic [FIELD_W-1:0] field_mask(input logic wide);
    return wide ? WIDE_MASK : NARROW_MASK;
  endfunction
endpackage

// File: rtl/sector_count_bank.sv
module sector_count_bank
  import sector_stats_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int AW    = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sector_walker.sv
module sector_walker #(
  parameter int MAX_SECTORS = 16,
  parameter int CNT_W       = 5,
  parameter int IDX_W       = 4,
  parameter int AW          = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] sector_cnt,
  output logic             accept,
  output logic             empty,
  output logic             busy,
  output logic [AW-1:0]    rd_addr,
  output logic             acc_vld,
  output logic             acc_last,
  output logic [1:0]       acc_lane
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_SECTORS);

  logic             busy_q;
  logic             vld_q;
  logic             last_q;
  logic [1:0]       lane_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] lim_q;
  logic [CNT_W-1:0] n_eff;
  logic             issue_last;

  always_comb begin
    n_eff      = (sector_cnt > CAP) ? CAP : sector_cnt;
    accept     = start && !busy_q && !vld_q;
    empty      = accept && (n_eff == '0);
    issue_last = busy_q && (idx_q == lim_q);
    rd_addr    = AW'(idx_q >> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      lane_q <= '0;
      idx_q  <= '0;
      lim_q  <= '0;
    end else begin
      vld_q  <= busy_q;
      last_q <= issue_last;
      lane_q <= idx_q[1:0];
      if (accept) begin
        busy_q <= (n_eff != '0);
        idx_q  <= '0;
        lim_q  <= IDX_W'(n_eff - CNT_W'(1));
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (issue_last) busy_q <= 1'b0;
      end
    end
  end

  assign busy     = busy_q;
  assign acc_vld  = vld_q;
  assign acc_last = last_q;
  assign acc_lane = lane_q;
endmodule

// File: rtl/sector_accum.sv
module sector_accum
  import sector_stats_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SUM_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               empty,
  input  logic               wide,
  input  logic               vld,
  input  logic               last,
  input  logic [1:0]         lane,
  input  logic [WORD_W-1:0]  word,
  output logic               done,
  output logic [CNT_W-1:0]   fail_cnt,
  output logic [SUM_W-1:0]   sum,
  output logic [FIELD_W-1:0] maxv,
  output logic [FIELD_W-1:0] mask
);
  logic [FIELD_W-1:0] lane_val [LANES];
  logic [FIELD_W-1:0] mask_q;
  logic [FIELD_W-1:0] masked;
  logic               is_fail;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_val[g] = word[g*LANE_W +: FIELD_W];
  end

  always_comb begin
    masked  = lane_val[lane] & mask_q;
    is_fail = (masked == mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      fail_cnt <= '0;
      sum      <= '0;
      maxv     <= '0;
      mask_q   <= NARROW_MASK;
    end else begin
      done <= 1'b0;
      if (clear) begin
        fail_cnt <= '0;
        sum      <= '0;
        maxv     <= '0;
        mask_q   <= field_mask(wide);
        done     <= empty;
      end else if (vld) begin
        if (is_fail) begin
          fail_cnt <= fail_cnt + CNT_W'(1);
        end else begin
          sum <= sum + SUM_W'(masked);
          if (masked > maxv) maxv <= masked;
        end
        done <= last;
      end
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/sector_err_stats.sv
module sector_err_stats
  import sector_stats_pkg::*;
#(
  parameter int MAX_SECTORS = 16,
  localparam int WORDS = (MAX_SECTORS + LANES - 1) / LANES,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W = $clog2(MAX_SECTORS + 1),
  localparam int IDX_W = $clog2(MAX_SECTORS),
  localparam int SUM_W = $clog2(int'(WIDE_MASK) * MAX_SECTORS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bank_we,
  input  logic [AW-1:0]      bank_waddr,
  input  logic [WORD_W-1:0]  bank_wdata,
  input  logic               start,
  input  logic [CNT_W-1:0]   sector_cnt,
  input  logic               wide_field,
  output logic               done,
  output logic [CNT_W-1:0]   failed_cnt,
  output logic [SUM_W-1:0]   corrected_sum,
  output logic [FIELD_W-1:0] max_flips
);
  logic               accept;
  logic               empty;
  logic               walk_busy;
  logic [AW-1:0]      rd_addr;
  logic               acc_vld;
  logic               acc_last;
  logic [1:0]         acc_lane;
  logic [WORD_W-1:0]  rd_word;
  logic [FIELD_W-1:0] cur_mask;

  sector_count_bank #(.WORDS(WORDS), .AW(AW)) u_bank (
    .clk   (clk),
    .we    (bank_we),
    .waddr (bank_waddr),
    .wdata (bank_wdata),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  sector_walker #(
    .MAX_SECTORS (MAX_SECTORS),
    .CNT_W       (CNT_W),
    .IDX_W       (IDX_W),
    .AW          (AW)
  ) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .sector_cnt (sector_cnt),
    .accept     (accept),
    .empty      (empty),
    .busy       (walk_busy),
    .rd_addr    (rd_addr),
    .acc_vld    (acc_vld),
    .acc_last   (acc_last),
    .acc_lane   (acc_lane)
  );

  sector_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .empty    (empty),
    .wide     (wide_field),
    .vld      (acc_vld),
    .last     (acc_last),
    .lane     (acc_lane),
    .word     (rd_word),
    .done     (done),
    .fail_cnt (failed_cnt),
    .sum      (corrected_sum),
    .maxv     (max_flips),
    .mask     (cur_mask)
  );
endmodule

// File: rtl/sector_err_stats_chk.sv
module sector_err_stats_chk #(
  parameter int CNT_W = 5,
  parameter int SUM_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             accept,
  input logic             walk_busy,
  input logic             acc_vld,
  input logic             done,
  input logic [CNT_W-1:0] failed_cnt,
  input logic [SUM_W-1:0] corrected_sum,
  input logic [6:0]       max_flips,
  input logic [6:0]       cur_mask
);
  // R6
  clear_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (failed_cnt == '0 && corrected_sum == '0 && max_flips == '0));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !walk_busy && !acc_vld) |=>
      ($stable(failed_cnt) && $stable(corrected_sum) && $stable(max_flips)));

  // R5
  max_within_sum_chk: assert property (@(posedge clk) disable iff (rst)
    SUM_W'(max_flips) <= corrected_sum);

  // R3
  max_below_mask_chk: assert property (@(posedge clk) disable iff (rst)
    max_flips < cur_mask);

  // R7
  done_after_walk_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !walk_busy);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    walk_busy |-> !accept);
endmodule

bind sector_err_stats sector_err_stats_chk #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .accept        (accept),
  .walk_busy     (walk_busy),
  .acc_vld       (acc_vld),
  .done          (done),
  .failed_cnt    (failed_cnt),
  .corrected_sum (corrected_sum),
  .max_flips     (max_flips),
  .cur_mask      (cur_mask)
);

// File: tb/tb_sector_err_stats.sv
module tb_sector_err_stats;
  localparam int MAXS  = 16;
  localparam int WORDS = 4;
  localparam int AW    = 2;
  localparam int CNT_W = 5;
  localparam int SUM_W = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1;
  logic             bank_we = 1'b0;
  logic [AW-1:0]    bank_waddr = '0;
  logic [31:0]      bank_wdata = '0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] sector_cnt = '0;
  logic             wide_field = 1'b0;
  logic             done;
  logic [CNT_W-1:0] failed_cnt;
  logic [SUM_W-1:0] corrected_sum;
  logic [6:0]       max_flips;

  sector_err_stats #(.MAX_SECTORS(MAXS)) dut (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_waddr(bank_waddr),
    .bank_wdata(bank_wdata), .start(start), .sector_cnt(sector_cnt),
    .wide_field(wide_field), .done(done), .failed_cnt(failed_cnt),
    .corrected_sum(corrected_sum), .max_flips(max_flips)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R9";

  typedef struct {int at; int f; int s; int m; bit dn;} snap_t;
  snap_t       q[$];
  logic [31:0] mem_m [WORDS];
  int          cyc = 0;
  int          done_edge = -1;
  bit          e_done = 0;
  int          e_f = 0, e_s = 0, e_m = 0;

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin : model
    snap_t r;
    int n, mk, f, s, m, v;
    cyc++;
    if (rst) begin
      q.delete();
      e_done = 0; e_f = 0; e_s = 0; e_m = 0;
      done_edge = -1;
    end else begin
      e_done = 0;
      while (q.size() > 0 && q[0].at == cyc) begin
        r = q.pop_front();
        e_f = r.f; e_s = r.s; e_m = r.m; e_done = r.dn;
      end
      if (bank_we) mem_m[bank_waddr] = bank_wdata;
      if (start && cyc > done_edge) begin
        n  = (int'(sector_cnt) > MAXS) ? MAXS : int'(sector_cnt);
        mk = wide_field ? 127 : 63;
        f = 0; s = 0; m = 0;
        e_f = 0; e_s = 0; e_m = 0;
        if (n == 0) begin
          e_done = 1;
          done_edge = cyc;
        end else begin
          for (int k = 0; k < n; k++) begin
            v = int'((mem_m[k/4] >> (8*(k%4))) & 32'(mk));
            if (v == mk) f++;
            else begin
              s += v;
              if (v > m) m = v;
            end
            r.at = cyc + k + 2; r.f = f; r.s = s; r.m = m; r.dn = (k == n-1);
            q.push_back(r);
          end
          done_edge = cyc + n + 1;
        end
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      cmp("done (R7)",          int'(done),          int'(e_done));
      cmp("failed_cnt (R3)",    int'(failed_cnt),    e_f);
      cmp("corrected_sum (R4)", int'(corrected_sum), e_s);
      cmp("max_flips (R5)",     int'(max_flips),     e_m);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bank_we = 1'b1; bank_waddr = AW'(a); bank_wdata = d;
    @(negedge clk);
    bank_we = 1'b0;
  endtask

  task automatic go(input int n, input bit w);
    @(negedge clk);
    start = 1'b1; sector_cnt = CNT_W'(n); wide_field = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    tag = "R9";
    cmp("reset done",   int'(done), 0);
    cmp("reset failed", int'(failed_cnt), 0);
    cmp("reset sum",    int'(corrected_sum), 0);
    cmp("reset max",    int'(max_flips), 0);
    rst = 1'b0;

    tag = "R1";
    wr(0, 32'h04030201); wr(1, 32'h08070605); wr(2, 0); wr(3, 0);
    go(8, 0); repeat (12) @(negedge clk);

    tag = "R2";
    wr(0, 32'hBF4081C5);
    go(4, 0); repeat (8) @(negedge clk);
    go(4, 1); repeat (8) @(negedge clk);

    tag = "R3";
    wr(2, 32'h7F3F7F01);
    go(12, 1); repeat (16) @(negedge clk);
    go(12, 0); repeat (16) @(negedge clk);

    tag = "R5";
    for (int i = 0; i < WORDS; i++) wr(i, 32'h0);
    go(16, 0); repeat (20) @(negedge clk);

    tag = "R8";
    go(0, 1); repeat (4) @(negedge clk);

    tag = "R10";
    wr(0, 32'h3F0A1203); wr(1, 32'h21050E7F); wr(2, 32'h00193F07);
    go(10, 0);
    repeat (2) @(negedge clk);
    start = 1'b1; sector_cnt = 5'd3; wide_field = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    start = 1'b1; sector_cnt = 5'd5; wide_field = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);

    tag = "R11";
    wr(3, 32'h01020304);
    go(31, 0); repeat (22) @(negedge clk);

    tag = "R9";
    repeat (10) @(negedge clk);

    tag = "R7";
    for (int it = 0; it < 24; it++) begin
      for (int w = 0; w < WORDS; w++) wr(w, $urandom);
      begin
        int n;
        n = int'($urandom_range(0, 20));
        go(n, bit'($urandom_range(0, 1)));
        repeat (n + 3) @(negedge clk);
      end
    end

    summary();
    $finish;
  end
endmodule